// File: doc/BRIEF.md
# Multicycle Fetch-Execute Processor Core

This block is a small 32-bit processor. It works through its program one instruction at a time. Each instruction is read from a single word-addressed synchronous memory and then executed. Instructions and data share that one memory port. The port has an address, write data, a write strobe and read data. A read returns its word one cycle after the address is presented.

The core holds thirty-two 32-bit general registers, a program counter and an adder/comparator datapath. Every instruction word has the same layout at the top: the operation code sits in bits 31:24. The core supports these operations:

- register add and immediate add
- word load and word store
- two signed compare-and-branch forms
- an indirect jump through a register
- a halt

A halt stops all fetching and raises a status output. A read-only register view then lets the surrounding environment inspect any register.

The asynchronous active-low reset is released to the core through a two-stage synchronizer. The core therefore starts fetching at address 0 on the third rising edge after reset is released.

Top module: `fe_core`

## Requirements
- R1: While reset is asserted, all 32 registers read 0, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0 (the PC resets to 0).
- R2: Register add, op code 0x01, with the layout [23:19] first source, [18:14] second source, [13:9] destination. It writes the 32-bit wrapping sum to the destination and advances the PC by 1.
- R3: Immediate add, op code 0x02, with the layout [23:19] source, [18:14] destination, [13:0] constant. The constant is sign-extended from 14 bits before it is added.
- R4: Load, op code 0x03, with the layout [23:19] destination, [18:5] constant, [4:0] base register. It reads the word at base + sign-extended constant into the destination.
- R5: Store, op code 0x04, with the layout [23:19] data register, [18:5] constant, [4:0] base register. It writes the data register to base + sign-extended constant, with `mem_we` high for exactly one cycle.
- R6: Branch if greater-or-equal, op code 0x05, with the layout [23:19] first operand, [18:14] second operand, [13:0] constant. The comparison is signed. When the branch is taken, the PC becomes the branch's own address plus the sign-extended constant; otherwise the PC becomes its address plus 1.
- R7: Branch if less-or-equal, op code 0x06, uses the same layout as R6. It is taken on a signed less-or-equal, including equality, and a negative constant branches backwards.
- R8: Jump, op code 0x07, with [23:19] naming a register. It loads the PC with that register's value.
- R9: Halt, op code 0xFF. After it executes, `halted` stays 1, `mem_we` stays 0, `mem_addr` holds still and no register or memory word changes.
- R10: Any other op code is a no-op. It changes no register and no memory word, and advances the PC by 1.
- R11: Instruction timing. A load takes 5 cycles from its fetch to the next fetch, and every other instruction takes 3. The halt raises `halted` 3 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Word address for instruction fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, one cycle per store |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_sel | input | 5 | Register index for the inspection view |
| dbg_data | output | 32 | Current value of the selected register |

## Verification
The hardest case to reach from the ports is a taken backward branch that closes a loop, and the signed comparisons that must give the opposite answer to an unsigned one. A second hard case is a load that reads back a word stored a few instructions earlier.

A directed program reaches these cases. It compares a positive register against a negative one in both directions and branches on equal operands. It runs a counted loop with a negative branch offset, jumps through a register, and places a disguised unknown op code where a misdecode would write a register.

Three random straight-line programs then mix adds, immediates, loads, stores and unknown op codes. Each run is compared, register for register and data word for data word, with an instruction-level model in the bench. The cycle count to halt is compared as well.

// File: rtl/fe_core_pkg.sv
`timescale 1ns/1ps
package fe_core_pkg;
  localparam int INSTR_W   = 32;
  localparam int OPC_W     = 8;
  localparam int REG_IDX_W = 5;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int CONST_W   = 14;

  localparam logic [OPC_W-1:0] OP_ADD   = 8'h01;
  localparam logic [OPC_W-1:0] OP_ADDI  = 8'h02;
  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h03;
  localparam logic [OPC_W-1:0] OP_STORE = 8'h04;
  localparam logic [OPC_W-1:0] OP_BGE   = 8'h05;
  localparam logic [OPC_W-1:0] OP_BLE   = 8'h06;
  localparam logic [OPC_W-1:0] OP_JUMP  = 8'h07;
  localparam logic [OPC_W-1:0] OP_HALT  = 8'hFF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEM,
    ST_WB,
    ST_HALT
  } core_state_e;
endpackage

// File: rtl/fe_regfile.sv
`timescale 1ns/1ps
module fe_regfile #(
  parameter  int W  = 32,
  parameter  int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [W-1:0]  rc_data
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
  assign rc_data = regs_q[rc_addr];
endmodule

// File: rtl/fe_alu.sv
`timescale 1ns/1ps
module fe_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] cmpb,
  output logic [W-1:0] sum,
  output logic         ge,
  output logic         le
);
  assign sum = opa + opb;
  assign ge  = $signed(opa) >= $signed(cmpb);
  assign le  = $signed(opa) <= $signed(cmpb);
endmodule

// File: rtl/fe_ctrl.sv
`timescale 1ns/1ps
module fe_ctrl
  import fe_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opc,
  output core_state_e       state
);
  core_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        if (opc == OP_LOAD)      state_d = ST_MEM;
        else if (opc == OP_HALT) state_d = ST_HALT;
        else                     state_d = ST_FETCH;
      end
      ST_MEM:    state_d = ST_WB;
      ST_WB:     state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/fe_core.sv
`timescale 1ns/1ps
module fe_core
  import fe_core_pkg::*;
#(
  parameter  int XLEN        = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int RW          = REG_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            halted,
  input  logic [RW-1:0]   dbg_sel,
  output logic [XLEN-1:0] dbg_data
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = sync_q[SYNC_STAGES-1];

  core_state_e          state_q;
  logic [INSTR_W-1:0]   ir_q;
  logic [XLEN-1:0]      pc_q, pc_d, mdr_q;
  logic                 pc_en, ir_en, mdr_en;

  // instruction fields
  logic [OPC_W-1:0]     opc;
  logic [RW-1:0]        f_a, f_b, f_c, f_base;
  logic [CONST_W-1:0]   k_hi, k_ls;
  logic                 is_ls, in_exec;

  assign opc    = ir_q[31:24];
  assign f_a    = ir_q[23:19];
  assign f_b    = ir_q[18:14];
  assign f_c    = ir_q[13:9];
  assign f_base = ir_q[4:0];
  assign k_hi   = ir_q[13:0];
  assign k_ls   = ir_q[18:5];
  assign is_ls  = (opc == OP_LOAD) || (opc == OP_STORE);
  assign in_exec = (state_q == ST_EXEC);

  // register file and datapath
  logic [RW-1:0]   rd_a, rd_b, wr_addr;
  logic [XLEN-1:0] a_val, b_val, imm, alu_b, sum, wr_data;
  logic            wr_en, ge, le;

  assign rd_a  = is_ls ? f_base : f_a;
  assign rd_b  = (opc == OP_STORE) ? f_a : f_b;
  assign imm   = is_ls ? {{(XLEN-CONST_W){k_ls[CONST_W-1]}}, k_ls}
                       : {{(XLEN-CONST_W){k_hi[CONST_W-1]}}, k_hi};
  assign alu_b = (opc == OP_ADD) ? b_val : imm;

  assign wr_en   = (in_exec && ((opc == OP_ADD) || (opc == OP_ADDI))) || (state_q == ST_WB);
  assign wr_addr = (state_q == ST_WB) ? f_a : ((opc == OP_ADD) ? f_c : f_b);
  assign wr_data = (state_q == ST_WB) ? mdr_q : sum;

  fe_regfile #(.W(XLEN), .N(NUM_REGS)) u_rf (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .ra_addr (rd_a),
    .ra_data (a_val),
    .rb_addr (rd_b),
    .rb_data (b_val),
    .rc_addr (dbg_sel),
    .rc_data (dbg_data)
  );

  fe_alu #(.W(XLEN)) u_alu (
    .opa  (a_val),
    .opb  (alu_b),
    .cmpb (b_val),
    .sum  (sum),
    .ge   (ge),
    .le   (le)
  );

  fe_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (core_rst_n),
    .opc   (opc),
    .state (state_q)
  );

  // program counter next value and enable
  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q + XLEN'(1);
    if (in_exec) begin
      unique case (opc)
        OP_LOAD, OP_HALT: pc_en = 1'b0;
        OP_BGE: begin
          pc_en = 1'b1;
          if (ge) pc_d = pc_q + imm;
        end
        OP_BLE: begin
          pc_en = 1'b1;
          if (le) pc_d = pc_q + imm;
        end
        OP_JUMP: begin
          pc_en = 1'b1;
          pc_d  = a_val;
        end
        default: pc_en = 1'b1;
      endcase
    end else if (state_q == ST_WB) begin
      pc_en = 1'b1;
    end
  end

  assign ir_en  = (state_q == ST_DECODE);
  assign mdr_en = (state_q == ST_MEM);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= mem_rdata[INSTR_W-1:0];
      if (mdr_en) mdr_q <= mem_rdata;
    end
  end

  assign mem_addr  = (in_exec && is_ls) ? sum : pc_q;
  assign mem_we    = in_exec && (opc == OP_STORE);
  assign mem_wdata = b_val;
  assign halted    = (state_q == ST_HALT);
endmodule

// File: rtl/fe_core_chk.sv
`timescale 1ns/1ps
module fe_core_chk
  import fe_core_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] pc,
  input core_state_e state,
  input logic [7:0]  opc
);
  logic unknown_op;
  assign unknown_op = !(opc inside {OP_ADD, OP_ADDI, OP_LOAD, OP_STORE,
                                    OP_BGE, OP_BLE, OP_JUMP, OP_HALT});

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(mem_addr)); // R9

  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && state == ST_FETCH); // R5

  AST_STORE_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> pc == $past(pc) + 32'd1); // R5

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |-> mem_addr == pc && !mem_we); // R11

  AST_ADD_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && opc == OP_ADD) |=> pc == $past(pc) + 32'd1); // R2

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && unknown_op) |=> pc == $past(pc) + 32'd1 && state == ST_FETCH && !mem_we); // R10

  AST_LOAD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && opc == OP_LOAD) |=> state == ST_MEM && $stable(pc)); // R4
endmodule

bind fe_core fe_core_chk u_fe_core_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .halted   (halted),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .pc       (pc_q),
  .state    (state_q),
  .opc      (ir_q[31:24])
);

// File: tb/test_fe_core.sv
`timescale 1ns/1ps
module test_fe_core;
  localparam int MEMW = 256;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_data;

  int total = 0;
  int bad   = 0;
  int cyc_all = 0;

  logic [31:0] mem     [MEMW];
  logic [31:0] img     [MEMW];
  logic [31:0] ref_mem [MEMW];
  logic [31:0] ref_rf  [32];

  always #4 clk = ~clk;

  fe_core i_fe_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc_all);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [13:0] k);
    return {{18{k[13]}}, k};
  endfunction
  function automatic logic [31:0] e_rr(input logic [7:0] op, input logic [4:0] s1, s2, d);
    return {op, s1, s2, d, 9'd0};
  endfunction
  function automatic logic [31:0] e_ri(input logic [7:0] op, input logic [4:0] a, b, input int k);
    logic [31:0] kk = k;
    return {op, a, b, kk[13:0]};
  endfunction
  function automatic logic [31:0] e_ls(input logic [7:0] op, input logic [4:0] r, input int k, input logic [4:0] base);
    logic [31:0] kk = k;
    return {op, r, kk[13:0], base};
  endfunction

  // instruction-level reference model
  task automatic run_ref(output int cyc);
    logic [31:0] pc = 0;
    cyc = 0;
    for (int i = 0; i < 32; i++) ref_rf[i] = 0;
    for (int i = 0; i < MEMW; i++) ref_mem[i] = img[i];
    for (int step = 0; step < 5000; step++) begin
      logic [31:0] ir = ref_mem[pc[7:0]];
      logic [4:0] a = ir[23:19], b = ir[18:14], c = ir[13:9], bs = ir[4:0];
      logic [31:0] npc = pc + 1;
      cyc += (ir[31:24] == 8'h03) ? 5 : 3;
      case (ir[31:24])
        8'h01: ref_rf[c] = ref_rf[a] + ref_rf[b];
        8'h02: ref_rf[b] = ref_rf[a] + sx(ir[13:0]);
        8'h03: ref_rf[a] = ref_mem[8'(ref_rf[bs] + sx(ir[18:5]))];
        8'h04: ref_mem[8'(ref_rf[bs] + sx(ir[18:5]))] = ref_rf[a];
        8'h05: if ($signed(ref_rf[a]) >= $signed(ref_rf[b])) npc = pc + sx(ir[13:0]);
        8'h06: if ($signed(ref_rf[a]) <= $signed(ref_rf[b])) npc = pc + sx(ir[13:0]);
        8'h07: npc = ref_rf[a];
        8'hFF: return;
        default: ;
      endcase
      pc = npc;
    end
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    dbg_sel = 5'(r);
    #1 v = dbg_data;
  endtask

  task automatic run_dut(input string name);
    int n = 0, exp_cyc;
    logic [31:0] v, hold_addr;
    logic mism;
    for (int i = 0; i < MEMW; i++) mem[i] = img[i];
    run_ref(exp_cyc);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", {name, " halted in reset"}, 32'(halted), 32'd0);
    chk("R1", {name, " mem_we in reset"}, 32'(mem_we), 32'd0);
    chk("R1", {name, " mem_addr in reset"}, mem_addr, 32'd0);
    mism = 1'b0;
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      if (v !== 32'd0) mism = 1'b1;
    end
    chk("R1", {name, " registers clear in reset"}, 32'(mism), 32'd0);
    rst_n = 1'b1;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted === 1'b1 || n > 4000) break;
    end
    chk("R11", {name, " cycles to halt"}, n, exp_cyc + SYNC);
    hold_addr = mem_addr;
    mism = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (halted !== 1'b1 || mem_we !== 1'b0 || mem_addr !== hold_addr) mism = 1'b1;
    end
    chk("R9", {name, " halt holds"}, 32'(mism), 32'd0);
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      chk("R2 R3 R4 R10", $sformatf("%s reg %0d", name, r), v, ref_rf[r]);
    end
    for (int i = 128; i < MEMW; i++)
      chk("R5 R10", $sformatf("%s mem %0d", name, i), mem[i], ref_mem[i]);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4321));
    rst_n   = 1'b0;
    dbg_sel = '0;

    // directed program
    for (int i = 0; i < MEMW; i++) img[i] = (i >= 128) ? $urandom : 32'd0;
    img[0]  = e_ri(8'h02, 31, 1, 5);
    img[1]  = e_ri(8'h02, 31, 2, -3);
    img[2]  = e_ri(8'h05, 1, 2, 3);        // taken signed
    img[3]  = e_ri(8'h02, 31, 3, 99);
    img[4]  = e_ri(8'h02, 31, 3, 98);
    img[5]  = e_ri(8'h06, 1, 2, 4);        // not taken
    img[6]  = e_ri(8'h06, 2, 2, 2);        // equal, taken
    img[7]  = e_ri(8'h02, 31, 4, 77);
    img[8]  = e_ls(8'h04, 1, 130, 31);
    img[9]  = e_ri(8'h02, 31, 5, 128);
    img[10] = e_ls(8'h03, 6, 2, 5);
    img[11] = e_ri(8'h02, 31, 7, 16);
    img[12] = {8'h07, 5'd7, 19'd0};
    img[13] = e_ri(8'h02, 31, 8, 1);
    img[14] = e_ri(8'h02, 31, 8, 1);
    img[15] = e_ri(8'h02, 31, 8, 1);
    img[16] = e_ri(8'hAB, 1, 12, 50);      // unknown op shaped like add-immediate
    img[17] = e_ri(8'h05, 2, 1, 5);        // not taken
    img[18] = e_ri(8'h02, 31, 9, -8192);
    img[19] = e_rr(8'h01, 9, 2, 10);
    img[20] = e_ri(8'h06, 31, 1, 3);
    img[21] = e_ri(8'h02, 31, 13, 1);
    img[23] = e_ri(8'h02, 11, 11, 1);
    img[24] = e_ri(8'h06, 11, 1, -1);      // backward loop
    img[25] = 32'hFF00_0000;
    run_dut("directed");
    rd_reg(3, v);  chk("R6", "BGE signed taken skips", v, 32'd0);
    rd_reg(4, v);  chk("R7", "BLE equal taken skips", v, 32'd0);
    rd_reg(9, v);  chk("R3", "min constant sign-extended", v, 32'hFFFF_E000);
    rd_reg(10, v); chk("R2", "register add wraps", v, 32'hFFFF_DFFD);
    rd_reg(6, v);  chk("R4", "load returns stored word", v, 32'd5);
    chk("R5", "store at base+const", mem[130], 32'd5);
    rd_reg(8, v);  chk("R8", "jump skips", v, 32'd0);
    rd_reg(12, v); chk("R10", "unknown op writes nothing", v, 32'd0);
    rd_reg(11, v); chk("R7", "backward loop count", v, 32'd6);
    rd_reg(13, v); chk("R7", "forward BLE skips", v, 32'd0);

    // random straight-line programs
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < MEMW; i++) img[i] = (i >= 128) ? $urandom : 32'd0;
      for (int i = 0; i < 40; i++) begin
        int kind = int'($urandom % 6);
        logic [4:0] s1 = 5'($urandom), s2 = 5'($urandom), d = 5'($urandom % 31);
        int k = int'($urandom % 16384);
        int dk = 128 + int'($urandom % 128);
        logic [7:0] uop;
        case ($urandom % 4)
          0: uop = 8'h00;
          1: uop = 8'h08;
          2: uop = 8'h80;
          default: uop = 8'hFE;
        endcase
        case (kind)
          0: img[i] = e_rr(8'h01, s1, s2, d);
          1, 2: img[i] = e_ri(8'h02, s1, d, k);
          3: img[i] = e_ls(8'h03, d, dk, 31);
          4: img[i] = e_ls(8'h04, s1, dk, 31);
          default: img[i] = {uop, 24'($urandom)};
        endcase
      end
      img[40] = 32'hFF00_0000;
      run_dut($sformatf("random%0d", p));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule